// File: doc/BRIEF.md
# Bipartite First-Quadrant Sine Evaluator

This block turns a folded phase word, an angle in the first quarter of a turn, into an unsigned sine amplitude. A single large table would hold one amplitude for every phase code. This block uses two small tables instead. A base table holds one value for each equal-length segment, taken at the midpoint of that segment. An offset table holds the linear correction that is added to or taken from the base value. Segments that lie next to each other share one slope, so the offset table is indexed by a coarse slope group together with the position of the code inside its segment.

The offsets are symmetric about each segment midpoint, so only the right-half magnitudes are stored. The top bit of the fine field picks add or subtract. For a left-half code, the remaining fine bits are inverted so that they index the mirrored entry. The result is clamped to the output range and registered once. With the default sizes the two tables hold 256 bits, against 2048 bits for a direct table. Both tables hold a scaled sine (peak 254 rather than 255) that was rounded when the design was built.

Top module: `bipartite_sine`

## Requirements
- R1: The phase word is split into a segment index (the top SEG_W bits), a slope group (the top GRP_W bits of the segment index) and a fine field (the low FINE_W bits). Segments in different slope groups have different offset profiles.
- R2: `amp_out` changes one clock edge after `phase_in` is sampled, and it holds its value while `phase_in` is steady.
- R3: An active-low `rst_n` clears `amp_out` to 0 at once. `amp_out` stays 0 while `rst_n` is low.
- R4: Inside any segment whose sums stay in range, each pair of mirrored codes (fine values g and 2^FINE_W-1-g) has the same output sum as every other pair in that segment.
- R5: A code whose fine MSB is 1 (right half) never gives less than its mirrored left-half code. A left-half subtraction never wraps below zero.
- R6: Segments in the same slope group share the same right-minus-left difference for every mirrored pair.
- R7: For every code X, `amp_out` is within 3 LSB of 254·sin(π/2·(X+0.5)/2^8).
- R8: A sum above 255 is clamped to 255. Codes 250 to 255 all give 255.
- R9: The default tables give these values: 0→1, 7→11, 8→13, 15→23, 50→78, 100→146, 128→182, 136→188, 200→239, 255→255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_in | input | 8 | Folded first-quadrant phase code |
| amp_out | output | 8 | Registered unsigned sine amplitude |

## Verification
The right-half addition and the saturation clamp can act on the same code. This happens in the last segment, where base value plus offset passes 255. The bench drives codes 248 to 255 back to back. It expects exactly 255 on each clamped code and the plain sum on the others, and it also holds every code to the real-sine error bound. Saturation would break the mirror-sum symmetry there, so that segment is left out of the symmetry and group-profile checks. All other segments are judged only through the relations between their own outputs.

// File: rtl/bipartite_sine.sv
module bipartite_sine #(
  parameter int SEG_W  = 4,
  parameter int GRP_W  = 2,
  parameter int FINE_W = 4,
  parameter int OUT_W  = 8,
  parameter int OFS_W  = 4,
  localparam int PH_W   = SEG_W + FINE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PH_W-1:0]  phase_in,
  output logic [OUT_W-1:0] amp_out
);

  localparam int HALF_W = FINE_W - 1;
  localparam int N_SEG  = 1 << SEG_W;
  localparam int N_OFS  = 1 << (GRP_W + HALF_W);

  localparam logic [OUT_W-1:0] BASE_TAB [N_SEG] = '{
    8'd12,  8'd37,  8'd62,  8'd86,  8'd109, 8'd131, 8'd151, 8'd171,
    8'd188, 8'd204, 8'd218, 8'd230, 8'd239, 8'd246, 8'd251, 8'd254
  };

  localparam logic [OFS_W-1:0] OFS_TAB [N_OFS] = '{
    4'd1, 4'd2, 4'd4, 4'd5, 4'd7, 4'd8, 4'd10, 4'd11,
    4'd1, 4'd2, 4'd3, 4'd5, 4'd6, 4'd7, 4'd8,  4'd10,
    4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6,  4'd6,
    4'd0, 4'd0, 4'd1, 4'd1, 4'd1, 4'd2, 4'd2,  4'd2
  };

  logic [SEG_W-1:0]  seg;
  logic [GRP_W-1:0]  grp;
  logic              right;
  logic [HALF_W-1:0] k;
  logic [OUT_W-1:0]  base;
  logic [OFS_W-1:0]  ofs;
  logic [OUT_W:0]    sum;
  logic [OUT_W-1:0]  amp_nxt;

  assign seg   = phase_in[PH_W-1 -: SEG_W];
  assign grp   = seg[SEG_W-1 -: GRP_W];
  assign right = phase_in[FINE_W-1];
  assign k     = right ? phase_in[HALF_W-1:0] : ~phase_in[HALF_W-1:0];
  assign base  = BASE_TAB[seg];
  assign ofs   = OFS_TAB[{grp, k}];

  assign sum = right ? {1'b0, base} + {{(OUT_W+1-OFS_W){1'b0}}, ofs}
                     : {1'b0, base} - {{(OUT_W+1-OFS_W){1'b0}}, ofs};

  assign amp_nxt = !sum[OUT_W] ? sum[OUT_W-1:0] : (right ? '1 : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) amp_out <= '0;
    else        amp_out <= amp_nxt;
  end

  p_reset_clear_r3: assert property (@(posedge clk) !rst_n |=> amp_out == '0)
    else $error("reset did not clear amp_out");

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable(phase_in)) |=> $stable(amp_out))
    else $error("amp_out moved with steady phase");

  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !right |-> ({{(OUT_W-OFS_W){1'b0}}, ofs} <= base))
    else $error("left-half offset exceeds base value");

  p_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (right && sum[OUT_W]) |=> amp_out == '1)
    else $error("overflowing sum not clamped");

endmodule

// File: tb/test_bipartite_sine.sv
module test_bipartite_sine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] phase_in = 8'd0;
  logic [7:0] amp_out;

  int nchk = 0;
  int nbad = 0;
  bit done = 1'b0;
  int res [256];

  localparam logic [15:0] VEC [10] = '{
    {8'd0, 8'd1}, {8'd7, 8'd11}, {8'd8, 8'd13}, {8'd15, 8'd23},
    {8'd50, 8'd78}, {8'd100, 8'd146}, {8'd128, 8'd182},
    {8'd136, 8'd188}, {8'd200, 8'd239}, {8'd255, 8'd255}
  };

  bipartite_sine i_bipartite_sine (
    .clk(clk), .rst_n(rst_n), .phase_in(phase_in), .amp_out(amp_out)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input int x, output int y);
    @(negedge clk) phase_in = x[7:0];
    @(negedge clk) y = int'(amp_out);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nbad++;
      nchk++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    int y;
    int ref0;
    int d0;
    int sum_a;
    int sum_b;
    real ideal;
    real err;
    repeat (3) @(negedge clk);
    chk(amp_out == 8'd0, "R3 reset", int'(amp_out), 0);
    rst_n = 1'b1;

    for (int i = 0; i < 10; i++) begin
      apply(int'(VEC[i][15:8]), y);
      chk(y == int'(VEC[i][7:0]), "R9 vector", y, int'(VEC[i][7:0]));
    end

    apply(0, y);
    @(negedge clk) phase_in = 8'd255;
    #1 chk(amp_out == 8'd1, "R2 before edge", int'(amp_out), 1);
    @(negedge clk) chk(amp_out == 8'd255, "R2 after edge", int'(amp_out), 255);
    repeat (3) @(negedge clk);
    chk(amp_out == 8'd255, "R2 hold", int'(amp_out), 255);

    for (int x = 0; x < 256; x++) begin
      apply(x, y);
      res[x] = y;
      ideal = 254.0 * $sin(3.14159265358979 * (real'(x) + 0.5) / 512.0);
      err = real'(y) - ideal;
      if (err < 0.0) err = -err;
      chk(err <= 3.0, "R7 sine error", y, int'(ideal + 0.5));
    end

    for (int x = 250; x < 256; x++)
      chk(res[x] == 255, "R8 clamp", res[x], 255);
    chk(res[248] == 254, "R8 no clamp", res[248], 254);

    for (int s = 0; s < 15; s++) begin
      ref0 = res[16*s] + res[16*s+15];
      for (int g = 1; g < 8; g++)
        chk(res[16*s+g] + res[16*s+15-g] == ref0, "R4 mirror sum",
            res[16*s+g] + res[16*s+15-g], ref0);
      for (int g = 0; g < 8; g++)
        chk(res[16*s+15-g] >= res[16*s+g], "R5 right vs left",
            res[16*s+15-g], res[16*s+g]);
    end

    for (int s = 0; s < 15; s++) begin
      int lead;
      lead = (s / 4) * 4;
      if (s != lead) begin
        for (int g = 0; g < 8; g++) begin
          d0 = res[16*lead+15-g] - res[16*lead+g];
          chk(res[16*s+15-g] - res[16*s+g] == d0, "R6 group profile",
              res[16*s+15-g] - res[16*s+g], d0);
        end
      end
    end

    sum_a = 0;
    sum_b = 0;
    for (int g = 0; g < 8; g++) begin
      sum_a += res[15-g] - res[g];
      sum_b += res[16*12+15-g] - res[16*12+g];
    end
    chk(sum_a != sum_b, "R1 groups differ", sum_a, sum_b);
    chk(sum_a == 96, "R1 group0 profile", sum_a, 96);

    @(negedge clk) phase_in = 8'd200;
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1 chk(amp_out == 8'd0, "R3 async clear", int'(amp_out), 0);
    @(negedge clk) chk(amp_out == 8'd0, "R3 held", int'(amp_out), 0);
    rst_n = 1'b1;
    @(negedge clk) chk(amp_out == 8'd239, "R3 recover", int'(amp_out), 239);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule